// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block keeps the control and status flags of one DMA channel. Software changes them with a single 32-bit control write. The upper half of the word is a per-bit enable, and the lower half holds the values to apply where an enable bit is set. Every flag whose enable bit is clear keeps its value. The full status word can be read at any time, and the request flags are driven as levels to the channel's command engine.

The command engine owns some of the flags:

- It raises and drops the active flag.
- It marks the channel dead after a fatal fetch error.
- It clears the flush and wake requests once it has handled them.
- It loads the branch-taken bit and the 8-bit device status field.

Software may clear dead and active but can never set them. The usual sequences are as follows. To stop, clear run and flush and poll until active and flush both read 0. To reset, clear active, dead, wake, flush, pause and run in one write and poll until run reads 0.

Top module: `dma_chan_csr`

## Requirements
- R1: A write with `csrWrEn` high changes status bit n (n in 15:0) only when word bit 16+n is 1, and then to word bit n. Bits whose enable is 0 keep their value, and the result reads back one cycle after the write.
- R2: Status bits 31:16 and bit 9 always read 0, whatever value is written to them.
- R3: Active (bit 10) becomes 1 one cycle after run (bit 15) reads 1, as long as dead (bit 11) is 0. It stays 1 while run stays 1.
- R4: After run reads 0, active stays 1 until the first cycle in which `engIdle` is 1. It reads 0 on the cycle after that.
- R5: A pulse on `engFatal` sets dead and clears active on the same edge. This wins over a software clear of dead in the same cycle. While dead is 1, active stays 0. Only a software write clears dead.
- R6: Flush (bit 13) is cleared by a pulse on `engFlushDone`. A software write that sets flush in the same cycle wins.
- R7: Wake (bit 12) is cleared by a pulse on `engWakeAck`. A software write that sets wake in the same cycle wins.
- R8: `engBtLoad` loads branch-taken (bit 8) from `engBtVal`, and `engDevLoad` loads device status (bits 7:0) from `engDevStat`. Any bit enabled by a software write in the same cycle takes the software value instead.
- R9: `runReq`, `pauseReq`, `flushReq` and `wakeReq` equal status bits 15, 14, 13 and 12.
- R10: After reset every status bit reads 0.
- R11: Software writes of 1 to active or dead are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csrWrEn | input | 1 | Control word write strobe |
| csrWrData | input | 32 | Enable mask in 31:16, new values in 15:0 |
| csrRdData | output | 32 | Current status word |
| runReq | output | 1 | Run flag to the engine |
| pauseReq | output | 1 | Pause flag to the engine |
| flushReq | output | 1 | Flush request to the engine |
| wakeReq | output | 1 | Wake request to the engine |
| engIdle | input | 1 | Engine has nothing in flight |
| engFatal | input | 1 | Fatal fetch error pulse |
| engFlushDone | input | 1 | Flush handled, clears flush |
| engWakeAck | input | 1 | Wake taken, clears wake |
| engBtLoad | input | 1 | Load branch-taken bit |
| engBtVal | input | 1 | Branch-taken value |
| engDevLoad | input | 1 | Load device status field |
| engDevStat | input | 8 | Device status value |

## Verification
Several flags can be changed by a software write and by an engine event on the same edge. The cases covered are:

- flush set against flush-done;
- wake set against wake-ack;
- a dead clear against a fatal error;
- a partial device-status write against an engine load of the whole field.

The bench drives both sources in the same cycle and reads the status word on the next one. Where software has priority, only the enabled bits must carry the software value and the other bits must take the engine's value. Where the error has priority, dead must be set and active must be clear.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int CSR_W  = 32;
  localparam int HALF_W = CSR_W / 2;
  localparam int DEV_W  = 8;

  localparam int BIT_RUN   = 15;
  localparam int BIT_PAUSE = 14;
  localparam int BIT_FLUSH = 13;
  localparam int BIT_WAKE  = 12;
  localparam int BIT_DEAD  = 11;
  localparam int BIT_ACT   = 10;
  localparam int BIT_BT    = 8;

  localparam logic [HALF_W-1:0] DEV_MASK = HALF_W'((1 << DEV_W) - 1);
  localparam logic [HALF_W-1:0] FLAG_SW  = HALF_W'((1 << BIT_RUN) | (1 << BIT_PAUSE) |
                                                   (1 << BIT_FLUSH) | (1 << BIT_WAKE) |
                                                   (1 << BIT_BT));
  // bits software may drive to 1
  localparam logic [HALF_W-1:0] SW_SET_OK = FLAG_SW | DEV_MASK;
  // bits software may drive to 0 (adds the engine-owned flags)
  localparam logic [HALF_W-1:0] SW_CLR_OK = SW_SET_OK |
                                            HALF_W'((1 << BIT_DEAD) | (1 << BIT_ACT));

  typedef struct packed {
    logic [HALF_W-1:0] setBits;
    logic [HALF_W-1:0] clrBits;
    logic              flushDone;
    logic              wakeAck;
    logic              fatal;
    logic              idle;
    logic              btLoad;
    logic              btVal;
    logic              devLoad;
    logic [DEV_W-1:0]  devVal;
  } csrStrobe_t;
endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
(
  input  logic             wrEn,
  input  logic [CSR_W-1:0] wrData,
  input  logic             engIdle,
  input  logic             engFatal,
  input  logic             engFlushDone,
  input  logic             engWakeAck,
  input  logic             engBtLoad,
  input  logic             engBtVal,
  input  logic             engDevLoad,
  input  logic [DEV_W-1:0] engDevStat,
  output csrStrobe_t       strobes
);
  logic [HALF_W-1:0] maskHalf;
  logic [HALF_W-1:0] valHalf;
  logic [HALF_W-1:0] setVec;
  logic [HALF_W-1:0] clrVec;

  assign maskHalf = wrData[CSR_W-1:HALF_W];
  assign valHalf  = wrData[HALF_W-1:0];

  // per-bit decode of the masked write into set and clear strobes
  for (genvar b = 0; b < HALF_W; b++) begin : g_bitDecode
    if (SW_SET_OK[b]) begin : g_set
      assign setVec[b] = wrEn & maskHalf[b] & valHalf[b];
    end else begin : g_noSet
      assign setVec[b] = 1'b0;
    end
    if (SW_CLR_OK[b]) begin : g_clr
      assign clrVec[b] = wrEn & maskHalf[b] & ~valHalf[b];
    end else begin : g_noClr
      assign clrVec[b] = 1'b0;
    end
  end

  always_comb begin
    strobes.setBits   = setVec;
    strobes.clrBits   = clrVec;
    strobes.flushDone = engFlushDone;
    strobes.wakeAck   = engWakeAck;
    strobes.fatal     = engFatal;
    strobes.idle      = engIdle;
    strobes.btLoad    = engBtLoad;
    strobes.btVal     = engBtVal;
    strobes.devLoad   = engDevLoad;
    strobes.devVal    = engDevStat;
  end
endmodule

// File: rtl/dma_csr_dp.sv
module dma_csr_dp
  import dma_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  csrStrobe_t       strobes,
  output logic [CSR_W-1:0] statusWord,
  output logic             runFlag,
  output logic             pauseFlag,
  output logic             flushFlag,
  output logic             wakeFlag
);
  logic             runQ, pauseQ, flushQ, wakeQ, deadQ, activeQ, btQ;
  logic [DEV_W-1:0] devQ;
  logic             killActive;

  // software-only flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ   <= 1'b0;
      pauseQ <= 1'b0;
    end else begin
      if (strobes.setBits[BIT_RUN])        runQ <= 1'b1;
      else if (strobes.clrBits[BIT_RUN])   runQ <= 1'b0;
      if (strobes.setBits[BIT_PAUSE])      pauseQ <= 1'b1;
      else if (strobes.clrBits[BIT_PAUSE]) pauseQ <= 1'b0;
    end
  end

  // self-clearing requests: software first, then engine acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flushQ <= 1'b0;
      wakeQ  <= 1'b0;
    end else begin
      if (strobes.setBits[BIT_FLUSH])      flushQ <= 1'b1;
      else if (strobes.clrBits[BIT_FLUSH]) flushQ <= 1'b0;
      else if (strobes.flushDone)          flushQ <= 1'b0;
      if (strobes.setBits[BIT_WAKE])       wakeQ <= 1'b1;
      else if (strobes.clrBits[BIT_WAKE])  wakeQ <= 1'b0;
      else if (strobes.wakeAck)            wakeQ <= 1'b0;
    end
  end

  // engine-owned flags: a fatal error outranks everything
  assign killActive = strobes.fatal | deadQ | strobes.clrBits[BIT_ACT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deadQ   <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      if (strobes.fatal)                  deadQ <= 1'b1;
      else if (strobes.clrBits[BIT_DEAD]) deadQ <= 1'b0;
      if (killActive)                     activeQ <= 1'b0;
      else if (runQ)                      activeQ <= 1'b1;
      else if (strobes.idle)              activeQ <= 1'b0;
    end
  end

  // branch-taken: software beats engine load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        btQ <= 1'b0;
    else if (strobes.setBits[BIT_BT])  btQ <= 1'b1;
    else if (strobes.clrBits[BIT_BT])  btQ <= 1'b0;
    else if (strobes.btLoad)           btQ <= strobes.btVal;
  end

  // device status, merged bit by bit
  for (genvar d = 0; d < DEV_W; d++) begin : g_devBit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   devQ[d] <= 1'b0;
      else if (strobes.setBits[d])  devQ[d] <= 1'b1;
      else if (strobes.clrBits[d])  devQ[d] <= 1'b0;
      else if (strobes.devLoad)     devQ[d] <= strobes.devVal[d];
    end
  end

  always_comb begin
    statusWord             = '0;
    statusWord[BIT_RUN]    = runQ;
    statusWord[BIT_PAUSE]  = pauseQ;
    statusWord[BIT_FLUSH]  = flushQ;
    statusWord[BIT_WAKE]   = wakeQ;
    statusWord[BIT_DEAD]   = deadQ;
    statusWord[BIT_ACT]    = activeQ;
    statusWord[BIT_BT]     = btQ;
    statusWord[DEV_W-1:0]  = devQ;
  end

  assign runFlag   = runQ;
  assign pauseFlag = pauseQ;
  assign flushFlag = flushQ;
  assign wakeFlag  = wakeQ;

  // R1
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.setBits[BIT_RUN] && !strobes.clrBits[BIT_RUN]) |=> $stable(runQ));
  // R3
  active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !deadQ && !strobes.fatal && !strobes.clrBits[BIT_ACT]) |=> activeQ);
  // R4
  active_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!runQ && strobes.idle) |=> !activeQ);
  // R5
  dead_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deadQ |-> !activeQ);
  // R5
  fatal_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.fatal |=> deadQ);
  // R6
  flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.flushDone && !strobes.setBits[BIT_FLUSH]) |=> !flushQ);
  // R7
  wake_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wakeAck && !strobes.setBits[BIT_WAKE]) |=> !wakeQ);
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csrWrEn,
  input  logic [CSR_W-1:0] csrWrData,
  output logic [CSR_W-1:0] csrRdData,
  output logic             runReq,
  output logic             pauseReq,
  output logic             flushReq,
  output logic             wakeReq,
  input  logic             engIdle,
  input  logic             engFatal,
  input  logic             engFlushDone,
  input  logic             engWakeAck,
  input  logic             engBtLoad,
  input  logic             engBtVal,
  input  logic             engDevLoad,
  input  logic [DEV_W-1:0] engDevStat
);
  csrStrobe_t strobes;

  dma_csr_ctrl u_ctrl (
    .wrEn         (csrWrEn),
    .wrData       (csrWrData),
    .engIdle      (engIdle),
    .engFatal     (engFatal),
    .engFlushDone (engFlushDone),
    .engWakeAck   (engWakeAck),
    .engBtLoad    (engBtLoad),
    .engBtVal     (engBtVal),
    .engDevLoad   (engDevLoad),
    .engDevStat   (engDevStat),
    .strobes      (strobes)
  );

  dma_csr_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .statusWord (csrRdData),
    .runFlag    (runReq),
    .pauseFlag  (pauseReq),
    .flushFlag  (flushReq),
    .wakeFlag   (wakeReq)
  );

  // R2
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csrRdData[CSR_W-1:HALF_W] == '0) && !csrRdData[9]);
  // R9
  req_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runReq == csrRdData[BIT_RUN]) && (flushReq == csrRdData[BIT_FLUSH]));
endmodule

// File: tb/dma_chan_csr_bench.sv
module dma_chan_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic        runReq, pauseReq, flushReq, wakeReq;
  logic        engIdle = 1'b1;
  logic        engFatal = 1'b0;
  logic        engFlushDone = 1'b0;
  logic        engWakeAck = 1'b0;
  logic        engBtLoad = 1'b0;
  logic        engBtVal = 1'b0;
  logic        engDevLoad = 1'b0;
  logic [7:0]  engDevStat = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_chan_csr u_dma_chan_csr (
    .clk(clk), .rst_n(rst_n), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(csrRdData), .runReq(runReq), .pauseReq(pauseReq),
    .flushReq(flushReq), .wakeReq(wakeReq), .engIdle(engIdle),
    .engFatal(engFatal), .engFlushDone(engFlushDone), .engWakeAck(engWakeAck),
    .engBtLoad(engBtLoad), .engBtVal(engBtVal), .engDevLoad(engDevLoad),
    .engDevStat(engDevStat)
  );

  // masked-write vectors applied from the reset state, engine quiet
  localparam int NVEC = 11;
  localparam logic [31:0] VEC_WR [NVEC] = '{
    32'h7000_7000, 32'h00FF_00A5, 32'h0200_0200, 32'h0100_0100,
    32'h4000_0000, 32'h000F_FFF0, 32'h0400_0400, 32'h0800_0800,
    32'h0000_FFFF, 32'h3100_0000, 32'h00FF_0000};
  localparam logic [31:0] VEC_EXP [NVEC] = '{
    32'h0000_7000, 32'h0000_70A5, 32'h0000_70A5, 32'h0000_71A5,
    32'h0000_31A5, 32'h0000_31A0, 32'h0000_31A0, 32'h0000_31A0,
    32'h0000_31A0, 32'h0000_00A0, 32'h0000_0000};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock edge; inputs were set at a negedge, results read at the next
  task automatic step();
    @(negedge clk);
    csrWrEn = 1'b0; engFatal = 1'b0; engFlushDone = 1'b0; engWakeAck = 1'b0;
    engBtLoad = 1'b0; engDevLoad = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    csrWrEn = 1'b1; csrWrData = d;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 reset status", csrRdData, 32'h0);
    check("R9 reqs after reset", {28'h0, runReq, pauseReq, flushReq, wakeReq}, 32'h0);

    // R1 / R2 / R11 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC_WR[i]);
      check($sformatf("R1/R2/R11 vector %0d", i), csrRdData, VEC_EXP[i]);
    end

    // R3: active follows run by one cycle
    wr(32'h8000_8000);
    check("R3 run set, active not yet", csrRdData, 32'h0000_8000);
    check("R9 runReq mirrors run", {31'h0, runReq}, 32'h1);
    step();
    check("R3 active one cycle later", csrRdData, 32'h0000_8400);

    // R4: active waits for engine idle
    engIdle = 1'b0;
    wr(32'h8000_0000);
    check("R4 active held while busy", csrRdData, 32'h0000_0400);
    step();
    check("R4 still busy", csrRdData, 32'h0000_0400);
    engIdle = 1'b1;
    step();
    check("R4 active dropped on idle", csrRdData, 32'h0000_0000);

    // R5: fatal error beats same-cycle dead clear
    wr(32'h8000_8000);
    step();
    check("R5 precondition active", csrRdData, 32'h0000_8400);
    engFatal = 1'b1;
    wr(32'h0800_0000);
    check("R5 fatal wins, active cleared", csrRdData, 32'h0000_8800);
    step();
    check("R5 active held low while dead", csrRdData, 32'h0000_8800);
    wr(32'h0800_0000);
    check("R5 software clears dead", csrRdData, 32'h0000_8000);
    step();
    check("R3 active returns after dead clear", csrRdData, 32'h0000_8400);
    wr(32'hFC00_0000);
    check("R5 reset write clears all flags", csrRdData, 32'h0000_0000);
    step();
    check("R4 active stays low after reset write", csrRdData, 32'h0000_0000);

    // R6: flush request and completion
    wr(32'h2000_2000);
    check("R9 flushReq mirrors flush", {31'h0, flushReq}, 32'h1);
    engFlushDone = 1'b1;
    step();
    check("R6 flush cleared by engine", csrRdData, 32'h0000_0000);
    engFlushDone = 1'b1;
    wr(32'h2000_2000);
    check("R6 same-cycle set wins", csrRdData, 32'h0000_2000);
    engFlushDone = 1'b1;
    step();
    check("R6 flush cleared afterwards", csrRdData, 32'h0000_0000);

    // R7: wake request and acknowledge
    wr(32'h1000_1000);
    check("R9 wakeReq mirrors wake", {31'h0, wakeReq}, 32'h1);
    engWakeAck = 1'b1;
    step();
    check("R7 wake cleared by ack", csrRdData, 32'h0000_0000);
    engWakeAck = 1'b1;
    wr(32'h1000_1000);
    check("R7 same-cycle set wins", csrRdData, 32'h0000_1000);
    wr(32'h1000_0000);

    // R8: engine loads and software priority
    engBtLoad = 1'b1; engBtVal = 1'b1;
    step();
    check("R8 engine loads branch-taken", csrRdData, 32'h0000_0100);
    engDevLoad = 1'b1; engDevStat = 8'h3C;
    step();
    check("R8 engine loads device status", csrRdData, 32'h0000_013C);
    engDevLoad = 1'b1; engDevStat = 8'hFF;
    wr(32'h000F_0000);
    check("R8 software nibble beats engine", csrRdData, 32'h0000_01F0);
    engBtLoad = 1'b1; engBtVal = 1'b0;
    wr(32'h0100_0100);
    check("R8 software bt beats engine", csrRdData, 32'h0000_01F0);

    // R2: reserved bits after an all-ones write
    wr(32'hFFFF_FFFF);
    check("R2 upper and bit 9 read zero", csrRdData & 32'hFFFF_0200, 32'h0);
    check("R11 active set only by run path", csrRdData & 32'h0000_0C00, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule